// File: doc/BRIEF.md
# Decimal Digit Segment Driver

This block takes a 4-bit unsigned code and an enable, and produces seven active-high lines that light the segments of one decimal digit. It is purely combinational: the segment lines follow the inputs with no clock, no storage and no latch. It drives a single digit only, so it has no multiplexing across digit positions, no decimal point and no letters.

Inside, the code feeds a 4-to-10 one-hot decoder with one line per decimal digit. Every segment is built as a NOR-style term over the few decoder lines for the digits that leave it dark. The result is then masked by the "some line is active" signal. That mask blanks the display when the enable is low and when the code is not a decimal digit. Without it, a NOR of all-zero lines would light every segment.

Segment numbering, used by every pin and requirement: bit 0 top, bit 1 upper-left, bit 2 upper-right, bit 3 middle, bit 4 lower-left, bit 5 lower-right, bit 6 bottom.

Top module: `digit_segment_driver`

## Requirements
- R1: With the enable at 1 and a code from 0 to 9, `seg_o` (bit 6 down to bit 0) is: 0→1110111, 1→0100100, 2→1011101, 3→1101101, 4→0101110, 5→1101011, 6→1111011, 7→0100101, 8→1111111, 9→0101111.
- R2: With the enable at 0, all seven segment lines are 0 for every code.
- R3: With the enable at 1 and a code from 10 to 15, all seven segment lines are 0.
- R4: The internal decoder has at most one active line. That line's index equals the unsigned code, and it is active exactly when the enable is 1 and the code is below 10.
- R5: Every displayed digit lights at least two segments. Digit 8 lights all seven. The lower-right segment (bit 5) is lit for every digit except 2.
- R6: The segment lines respond to a change of enable or code without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_i | input | 1 | Display enable; 0 blanks every segment |
| code_i | input | 4 | Unsigned digit code; 10 to 15 blank the display |
| seg_o | output | 7 | Active-high segment lines, bit 0 top through bit 6 bottom |

## Verification
The block holds no state, so a wrong decoder line or a wrong dark-digit mask shows up at `seg_o` in the same evaluation as the input that selects it. The fault never lasts beyond that input.

Each fault therefore surfaces only for the codes that reach it. That is why all 32 enable/code pairs are swept. A missing output mask would light all seven segments for disabled or out-of-range codes. A swapped dark set would leave one segment wrong for a handful of digits.

// File: rtl/digit_seg_pkg.sv
package digit_seg_pkg;
  localparam int unsigned CODE_W     = 4;
  localparam int unsigned NUM_DIGITS = 10;
  localparam int unsigned NUM_SEGS   = 7;

  typedef logic [NUM_DIGITS-1:0] digit_lines_t;
  typedef logic [NUM_SEGS-1:0]   seg_vec_t;

  // Mask of digits for which a given segment stays dark (bit d = digit d).
  function automatic digit_lines_t dark_digits(input int unsigned seg_idx);
    case (seg_idx)
      0:       dark_digits = 10'h012; // top: 1,4
      1:       dark_digits = 10'h08E; // upper-left: 1,2,3,7
      2:       dark_digits = 10'h060; // upper-right: 5,6
      3:       dark_digits = 10'h083; // middle: 0,1,7
      4:       dark_digits = 10'h2BA; // lower-left: 1,3,4,5,7,9
      5:       dark_digits = 10'h004; // lower-right: 2
      6:       dark_digits = 10'h292; // bottom: 1,4,7,9
      default: dark_digits = '0;
    endcase
  endfunction
endpackage

// File: rtl/digit_onehot_decoder.sv
module digit_onehot_decoder #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned LINES  = 10
) (
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [LINES-1:0]  line_o
);
  // One line per decimal digit; codes at or beyond LINES raise nothing.
  for (genvar d = 0; d < LINES; d++) begin : g_line
    assign line_o[d] = en_i && (code_i == CODE_W'(d));
  end
endmodule

// File: rtl/segment_nor_plane.sv
module segment_nor_plane
  import digit_seg_pkg::*;
#(
  parameter int unsigned LINES = NUM_DIGITS,
  parameter int unsigned SEGS  = NUM_SEGS
) (
  input  logic [LINES-1:0] line_i,
  output logic [SEGS-1:0]  seg_o
);
  // Any active line means a valid, enabled digit is present.
  logic any_line;
  assign any_line = |line_i;

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    localparam digit_lines_t DARK = dark_digits(s);
    logic dark_hit;
    assign dark_hit = |(line_i & DARK[LINES-1:0]);
    // NOR of the dark lines, masked so an idle decoder lights nothing.
    assign seg_o[s] = any_line & ~dark_hit;
  end
endmodule

// File: rtl/digit_segment_driver.sv
module digit_segment_driver
  import digit_seg_pkg::*;
(
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [NUM_SEGS-1:0] seg_o
);
  digit_lines_t dec_lines;

  digit_onehot_decoder #(
    .CODE_W (CODE_W),
    .LINES  (NUM_DIGITS)
  ) u_dec (
    .en_i   (en_i),
    .code_i (code_i),
    .line_o (dec_lines)
  );

  segment_nor_plane #(
    .LINES (NUM_DIGITS),
    .SEGS  (NUM_SEGS)
  ) u_plane (
    .line_i (dec_lines),
    .seg_o  (seg_o)
  );
endmodule

// File: rtl/digit_segment_checker.sv
module digit_segment_checker
  import digit_seg_pkg::*;
(
  input logic                en,
  input logic [CODE_W-1:0]   code,
  input logic [NUM_SEGS-1:0] seg,
  input digit_lines_t        lines
);
  always_comb begin
    // R2: disabled means dark
    if (!en) a_r2_disabled_dark: assert (seg == '0);
    // R3: non-decimal codes blank the display
    if (code >= CODE_W'(NUM_DIGITS)) a_r3_code_blank: assert (seg == '0);
    // R4: decoder has at most one line, matching the code
    a_r4_onehot: assert ($onehot0(lines));
    if (|lines) a_r4_line_index: assert (lines == (digit_lines_t'(1) << code));
    if (en && code < CODE_W'(NUM_DIGITS)) a_r4_line_active: assert (|lines);
    // R5: a displayed digit lights at least two segments; lower-right dark only for 2
    if (|lines) a_r5_min_segs: assert ($countones(seg) >= 2);
    if (|lines && code != CODE_W'(2)) a_r5_lower_right: assert (seg[5]);
  end
endmodule

bind digit_segment_driver digit_segment_checker u_chk (
  .en    (en_i),
  .code  (code_i),
  .seg   (seg_o),
  .lines (dec_lines)
);

// File: tb/tb_digit_segment_driver.sv
module tb_digit_segment_driver;
  logic       clk = 1'b0;
  logic       en;
  logic [3:0] code;
  logic [6:0] seg;
  int         checks = 0;
  int         errors = 0;
  bit         done   = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  digit_segment_driver dut (.en_i(en), .code_i(code), .seg_o(seg));

  function automatic logic [6:0] ref_seg(input logic e, input logic [3:0] c);
    if (!e) return 7'b0;                   // R2
    case (c)                               // R1, bit 6 .. bit 0
      4'd0: return 7'b1110111;
      4'd1: return 7'b0100100;
      4'd2: return 7'b1011101;
      4'd3: return 7'b1101101;
      4'd4: return 7'b0101110;
      4'd5: return 7'b1101011;
      4'd6: return 7'b1111011;
      4'd7: return 7'b0100101;
      4'd8: return 7'b1111111;
      4'd9: return 7'b0101111;
      default: return 7'b0;                // R3
    endcase
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    checks++;
    if (seg !== exp) begin
      errors++;
      $display("FAIL %s en=%0b code=%0d actual=%b expected=%b", req, en, code, seg, exp);
    end
  endtask

  initial begin
    en = 1'b0; code = 4'd0;
    #2 check("R2 initial blank", 7'b0);
    // Exhaustive sweep over all 32 enable/code pairs
    for (int e = 0; e < 2; e++) begin
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        en = e[0]; code = c[3:0];
        #2;
        if (!en)          check("R2", ref_seg(en, code));
        else if (c >= 10) check("R3", ref_seg(en, code));
        else              check("R1", ref_seg(en, code));
      end
    end
    // R5: digit 8 all lit; lower-right only dark for digit 2
    @(negedge clk); en = 1'b1; code = 4'd8; #1 check("R5 digit 8", 7'h7F);
    for (int c = 0; c < 10; c++) begin
      code = c[3:0]; #1;
      checks++;
      if ((seg[5] !== (c != 2)) || ($countones(seg) < 2)) begin
        errors++;
        $display("FAIL R5 code=%0d actual=%b expected lower-right=%0b", c, seg, (c != 2));
      end
    end
    // R6: changes between clock edges show up without an edge
    @(posedge clk); #1;
    code = 4'd3; #1 check("R6 mid-cycle code", 7'b1101101);
    en = 1'b0;   #1 check("R6 mid-cycle disable", 7'b0);
    en = 1'b1;   #1 check("R6 mid-cycle enable", 7'b1101101);
    code = 4'd12; #1 check("R6 mid-cycle invalid", 7'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule